// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits in front of the ALU in the execute stage of a five-stage in-order pipeline. It decides where each of the two ALU operands comes from. The candidates are the value read from the register file, the result waiting in the EX/MEM pipeline register, the value about to be written back from the MEM/WB register, and, for the second operand only, the immediate word carried by the instruction. A read-after-write dependency between back-to-back instructions is therefore resolved without waiting for the register file write.

The same idea is applied to the condition flags (zero, negative, carry). A conditional jump in execute sees flags from EX/MEM if that instruction updates them. Failing that, it sees flags from MEM/WB. Otherwise it sees the architectural flag register. The block is purely combinational. Each operand also drives out the 2-bit source code it used, so that stall logic or a trace monitor can observe the decision.

Top module: `fwd_select`

## Requirements
- R1: When `exm_wr_en` is 1 and `exm_dst` equals an operand's source index, that operand equals `exm_result` and its select code is 2 (EX/MEM).
- R2: When only the MEM/WB stage matches (`wb_wr_en` is 1 and `wb_dst` equals the source index), the operand takes the MEM/WB value and its select code is 1 (MEM/WB).
- R3: The MEM/WB value is `wb_load_data` when `wb_from_mem` is 1, and `wb_alu_result` when it is 0.
- R4: When no path matches and no immediate applies, operand A equals `rf_data_a`, operand B equals `rf_data_b`, and the select code is 0 (register file).
- R5: When both EX/MEM and MEM/WB match the same source index, the EX/MEM result is chosen (code 2).
- R6: When `imm_valid` is 1, operand B equals `imm_value` and `sel_b` is 3 (immediate), whatever the forwarding matches are.
- R7: Operand A never selects the immediate. `imm_valid` has no effect on `op_a` or `sel_a`, and `sel_a` never equals 3.
- R8: A stage whose write enable is 0 is never forwarded from, even when its destination index equals the source index.
- R9: `flags_out` equals `exm_flags` with `flag_sel` 2 when `exm_flag_wr` is 1. Otherwise it equals `wb_flags` with `flag_sel` 1 when `wb_flag_wr` is 1. Otherwise it equals `ccr_flags` with `flag_sel` 0. The flag vector is passed through unchanged: bit 0 zero, bit 1 negative, bit 2 carry.
- R10: Register index 0 is forwarded like any other index. It is not treated as a constant zero register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 3 | Source register index of operand A |
| src_b | input | 3 | Source register index of operand B |
| imm_valid | input | 1 | Instruction in execute carries an immediate for operand B |
| imm_value | input | 32 | Immediate word |
| exm_wr_en | input | 1 | EX/MEM instruction writes a register |
| exm_dst | input | 3 | EX/MEM destination index |
| exm_result | input | 32 | EX/MEM ALU result |
| exm_flag_wr | input | 1 | EX/MEM instruction updates the flags |
| exm_flags | input | 3 | EX/MEM flag values |
| wb_wr_en | input | 1 | MEM/WB instruction writes a register |
| wb_dst | input | 3 | MEM/WB destination index |
| wb_alu_result | input | 32 | MEM/WB ALU result |
| wb_from_mem | input | 1 | MEM/WB writes back loaded data |
| wb_load_data | input | 32 | MEM/WB loaded memory data |
| wb_flag_wr | input | 1 | MEM/WB instruction updates the flags |
| wb_flags | input | 3 | MEM/WB flag values |
| rf_data_a | input | 32 | Register file read data for operand A |
| rf_data_b | input | 32 | Register file read data for operand B |
| ccr_flags | input | 3 | Architectural flag register |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |
| sel_a | output | 2 | Source code for A: 0 RF, 1 MEM/WB, 2 EX/MEM |
| sel_b | output | 2 | Source code for B: 0 RF, 1 MEM/WB, 2 EX/MEM, 3 immediate |
| flags_out | output | 3 | Selected flags |
| flag_sel | output | 2 | Flag source code: 0 flag register, 1 MEM/WB, 2 EX/MEM |

## Verification
The assertions are immediate checks on the settled combinational outputs. They assume that every input is a defined 0 or 1 and that the inputs are stable while they are evaluated. The stimulus supports this by changing all inputs together just after a rising edge and leaving them unchanged until the next one. The assertions also assume that the source codes 1 and 2 correspond to real write-enable and index matches. The bench produces those matches only by deliberately setting a stage's destination equal to, or different from, the source index. It gives every candidate data word a distinct value, so any wrong selection shows up as a visible mismatch.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int IDX_W  = 3;
  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_EXM = 2'd2,
    SRC_IMM = 2'd3
  } src_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int IDX_W = 3
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst,
  input  logic [IDX_W-1:0] src,
  output logic             hit
);
  // a stage only supplies data when it really writes the wanted register
  assign hit = wr_en && (dst == src);
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter bit ALLOW_IMM = 1'b0
) (
  input  logic              imm_valid,
  input  logic [DATA_W-1:0] imm_value,
  input  logic              exm_hit,
  input  logic              wb_hit,
  input  logic [DATA_W-1:0] exm_data,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [DATA_W-1:0] rf_data,
  output logic [DATA_W-1:0] operand,
  output logic [1:0]        sel
);
  logic     imm_use;
  src_sel_e choice;

  generate
    if (ALLOW_IMM) begin : g_imm
      assign imm_use = imm_valid;
    end else begin : g_no_imm
      logic unused_imm;
      assign unused_imm = ^{imm_valid, imm_value};
      assign imm_use    = 1'b0;
    end
  endgenerate

  // fixed order: immediate, newest forward, older forward, register file
  always_comb begin
    if (imm_use)      choice = SRC_IMM;
    else if (exm_hit) choice = SRC_EXM;
    else if (wb_hit)  choice = SRC_WB;
    else              choice = SRC_RF;
  end

  always_comb begin
    unique case (choice)
      SRC_IMM: operand = imm_value;
      SRC_EXM: operand = exm_data;
      SRC_WB:  operand = wb_data;
      default: operand = rf_data;
    endcase
  end

  assign sel = choice;
endmodule

// File: rtl/fwd_flag_sel.sv
module fwd_flag_sel
  import fwd_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic              exm_flag_wr,
  input  logic [FLAG_W-1:0] exm_flags,
  input  logic              wb_flag_wr,
  input  logic [FLAG_W-1:0] wb_flags,
  input  logic [FLAG_W-1:0] ccr_flags,
  output logic [FLAG_W-1:0] flags_out,
  output logic [1:0]        flag_sel
);
  src_sel_e choice;

  always_comb begin
    if (exm_flag_wr) begin
      choice    = SRC_EXM;
      flags_out = exm_flags;
    end else if (wb_flag_wr) begin
      choice    = SRC_WB;
      flags_out = wb_flags;
    end else begin
      choice    = SRC_RF;
      flags_out = ccr_flags;
    end
  end

  assign flag_sel = choice;
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  input  logic              imm_valid,
  input  logic [DATA_W-1:0] imm_value,
  input  logic              exm_wr_en,
  input  logic [IDX_W-1:0]  exm_dst,
  input  logic [DATA_W-1:0] exm_result,
  input  logic              exm_flag_wr,
  input  logic [FLAG_W-1:0] exm_flags,
  input  logic              wb_wr_en,
  input  logic [IDX_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_alu_result,
  input  logic              wb_from_mem,
  input  logic [DATA_W-1:0] wb_load_data,
  input  logic              wb_flag_wr,
  input  logic [FLAG_W-1:0] wb_flags,
  input  logic [DATA_W-1:0] rf_data_a,
  input  logic [DATA_W-1:0] rf_data_b,
  input  logic [FLAG_W-1:0] ccr_flags,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [FLAG_W-1:0] flags_out,
  output logic [1:0]        flag_sel
);
  localparam int N_OPS = 2;

  logic [DATA_W-1:0] wb_fwd_data;
  logic [IDX_W-1:0]  src_idx  [N_OPS];
  logic [DATA_W-1:0] rf_data  [N_OPS];
  logic [DATA_W-1:0] op_data  [N_OPS];
  logic [1:0]        op_sel   [N_OPS];
  logic              exm_hit  [N_OPS];
  logic              wb_hit   [N_OPS];

  // the write-back value is the loaded word for loads, else the ALU result
  assign wb_fwd_data = wb_from_mem ? wb_load_data : wb_alu_result;

  assign src_idx[0] = src_a;
  assign src_idx[1] = src_b;
  assign rf_data[0] = rf_data_a;
  assign rf_data[1] = rf_data_b;

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
      fwd_hit #(.IDX_W(IDX_W)) u_exm_hit (
        .wr_en (exm_wr_en),
        .dst   (exm_dst),
        .src   (src_idx[g]),
        .hit   (exm_hit[g])
      );

      fwd_hit #(.IDX_W(IDX_W)) u_wb_hit (
        .wr_en (wb_wr_en),
        .dst   (wb_dst),
        .src   (src_idx[g]),
        .hit   (wb_hit[g])
      );

      // only the second operand can be replaced by the immediate
      fwd_operand_mux #(.DATA_W(DATA_W), .ALLOW_IMM(g == 1)) u_mux (
        .imm_valid (imm_valid),
        .imm_value (imm_value),
        .exm_hit   (exm_hit[g]),
        .wb_hit    (wb_hit[g]),
        .exm_data  (exm_result),
        .wb_data   (wb_fwd_data),
        .rf_data   (rf_data[g]),
        .operand   (op_data[g]),
        .sel       (op_sel[g])
      );
    end
  endgenerate

  assign op_a  = op_data[0];
  assign op_b  = op_data[1];
  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  fwd_flag_sel #(.FLAG_W(FLAG_W)) u_flags (
    .exm_flag_wr (exm_flag_wr),
    .exm_flags   (exm_flags),
    .wb_flag_wr  (wb_flag_wr),
    .wb_flags    (wb_flags),
    .ccr_flags   (ccr_flags),
    .flags_out   (flags_out),
    .flag_sel    (flag_sel)
  );
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  src_a,
  input logic [IDX_W-1:0]  src_b,
  input logic              imm_valid,
  input logic [DATA_W-1:0] imm_value,
  input logic              exm_wr_en,
  input logic [IDX_W-1:0]  exm_dst,
  input logic [DATA_W-1:0] exm_result,
  input logic              exm_flag_wr,
  input logic [FLAG_W-1:0] exm_flags,
  input logic              wb_wr_en,
  input logic [IDX_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_alu_result,
  input logic              wb_from_mem,
  input logic [DATA_W-1:0] wb_load_data,
  input logic              wb_flag_wr,
  input logic [FLAG_W-1:0] wb_flags,
  input logic [DATA_W-1:0] rf_data_a,
  input logic [DATA_W-1:0] rf_data_b,
  input logic [FLAG_W-1:0] ccr_flags,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [FLAG_W-1:0] flags_out,
  input logic [1:0]        flag_sel
);
  always_comb begin
    // R1: an EX/MEM selection delivers the EX/MEM result
    p_exm_value_r1: assert ((sel_a != SRC_EXM || op_a == exm_result) &&
                            (sel_b != SRC_EXM || op_b == exm_result));
    // R3: a MEM/WB selection delivers load data or ALU result
    p_wb_value_r3: assert (sel_a != SRC_WB ||
                           op_a == (wb_from_mem ? wb_load_data : wb_alu_result));
    // R4: register file selections pass the read data
    p_rf_value_r4: assert ((sel_a != SRC_RF || op_a == rf_data_a) &&
                           (sel_b != SRC_RF || op_b == rf_data_b));
    // R5: an older path never wins while EX/MEM matches
    p_exm_first_r5: assert (sel_a != SRC_WB || !(exm_wr_en && exm_dst == src_a));
    // R6: the immediate overrides every path for operand B
    p_imm_b_r6: assert (!imm_valid || (sel_b == SRC_IMM && op_b == imm_value));
    // R7: operand A never reports the immediate
    p_no_imm_a_r7: assert (sel_a != SRC_IMM);
    // R8: a forward code requires the stage write enable
    p_wen_gate_r8: assert ((sel_b != SRC_EXM || exm_wr_en) &&
                           (sel_b != SRC_WB || (wb_wr_en && wb_dst == src_b)));
    // R9: the flag source code matches the delivered flags
    p_flags_r9: assert ((flag_sel == SRC_EXM && flags_out == exm_flags && exm_flag_wr) ||
                        (flag_sel == SRC_WB && flags_out == wb_flags && wb_flag_wr) ||
                        (flag_sel == SRC_RF && flags_out == ccr_flags));
  end
endmodule

bind fwd_select fwd_select_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_fwd_select.sv
module tb_fwd_select;
  localparam int DW = 32;

  localparam logic [DW-1:0] V_EXM  = 32'hE0E0_0001;
  localparam logic [DW-1:0] V_WALU = 32'h3B3B_0002;
  localparam logic [DW-1:0] V_LOAD = 32'h10AD_0003;
  localparam logic [DW-1:0] V_RFA  = 32'hAAAA_0004;
  localparam logic [DW-1:0] V_RFB  = 32'hBBBB_0005;
  localparam logic [DW-1:0] V_IMM  = 32'h1111_0006;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0] src_a, src_b, exm_dst, wb_dst;
  logic imm_valid, exm_wr_en, exm_flag_wr, wb_wr_en, wb_from_mem, wb_flag_wr;
  logic [DW-1:0] imm_value, exm_result, wb_alu_result, wb_load_data, rf_data_a, rf_data_b;
  logic [2:0] exm_flags, wb_flags, ccr_flags, flags_out;
  logic [DW-1:0] op_a, op_b;
  logic [1:0] sel_a, sel_b, flag_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_select #(.DATA_W(DW)) dut (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_a = 3'd3; src_b = 3'd5; exm_dst = 3'd6; wb_dst = 3'd7;
    imm_valid = 0; exm_wr_en = 0; exm_flag_wr = 0; wb_wr_en = 0;
    wb_from_mem = 0; wb_flag_wr = 0;
    imm_value = V_IMM; exm_result = V_EXM; wb_alu_result = V_WALU;
    wb_load_data = V_LOAD; rf_data_a = V_RFA; rf_data_b = V_RFB;
    exm_flags = 3'b001; wb_flags = 3'b010; ccr_flags = 3'b100;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R4 reset sel_a", {30'd0, sel_a}, 0);
    chk("R4 reset op_a", op_a, V_RFA);
    chk("R4 reset op_b", op_b, V_RFB);
    chk("R9 reset flags", {29'd0, flags_out}, {29'd0, 3'b100});
  endtask

  // every ex/wb/imm combination, both operands reading the same register
  task automatic t_combos();
    for (int m = 0; m < 8; m++) begin
      logic ex, wb, im;
      logic [1:0] ea, eb;
      logic [DW-1:0] va, vb;
      ex = m[0]; wb = m[1]; im = m[2];
      @(posedge clk);
      idle();
      src_a = 3'd3; src_b = 3'd3;
      exm_wr_en = 1; wb_wr_en = 1;
      exm_dst = ex ? 3'd3 : 3'd1;
      wb_dst  = wb ? 3'd3 : 3'd2;
      imm_valid = im;
      ea = ex ? 2'd2 : (wb ? 2'd1 : 2'd0);
      va = ex ? V_EXM : (wb ? V_WALU : V_RFA);
      eb = im ? 2'd3 : (ex ? 2'd2 : (wb ? 2'd1 : 2'd0));
      vb = im ? V_IMM : (ex ? V_EXM : (wb ? V_WALU : V_RFB));
      @(negedge clk);
      chk("R1 R2 R4 R5 R7 sel_a", {30'd0, sel_a}, {30'd0, ea});
      chk("R1 R2 R4 R5 R7 op_a", op_a, va);
      chk("R1 R2 R4 R5 R6 sel_b", {30'd0, sel_b}, {30'd0, eb});
      chk("R1 R2 R4 R5 R6 op_b", op_b, vb);
    end
  endtask

  task automatic t_wb_mem();
    @(posedge clk);
    idle();
    wb_wr_en = 1; wb_dst = 3'd5; wb_from_mem = 1;
    @(negedge clk);
    chk("R3 load data to B", op_b, V_LOAD);
    chk("R3 sel_b", {30'd0, sel_b}, 1);
    chk("R4 A untouched", op_a, V_RFA);
  endtask

  task automatic t_wen_low();
    @(posedge clk);
    idle();
    exm_dst = 3'd3; wb_dst = 3'd5;
    @(negedge clk);
    chk("R8 A no forward", op_a, V_RFA);
    chk("R8 B no forward", op_b, V_RFB);
    chk("R8 sel_b", {30'd0, sel_b}, 0);
  endtask

  task automatic t_split_srcs();
    @(posedge clk);
    idle();
    exm_wr_en = 1; exm_dst = 3'd3; wb_wr_en = 1; wb_dst = 3'd5;
    @(negedge clk);
    chk("R1 A from EX/MEM", op_a, V_EXM);
    chk("R2 B from MEM/WB", op_b, V_WALU);
  endtask

  task automatic t_reg_zero();
    @(posedge clk);
    idle();
    src_a = 3'd0; src_b = 3'd0; exm_wr_en = 1; exm_dst = 3'd0;
    @(negedge clk);
    chk("R10 index 0 forwarded A", op_a, V_EXM);
    chk("R10 index 0 forwarded B", op_b, V_EXM);
  endtask

  task automatic t_imm_a_ignored();
    @(posedge clk);
    idle();
    imm_valid = 1;
    @(negedge clk);
    chk("R7 A ignores imm", op_a, V_RFA);
    chk("R7 sel_a", {30'd0, sel_a}, 0);
    chk("R6 B takes imm", op_b, V_IMM);
  endtask

  task automatic t_flags();
    for (int m = 0; m < 4; m++) begin
      logic [2:0] ef;
      logic [1:0] es;
      @(posedge clk);
      idle();
      exm_flag_wr = m[0]; wb_flag_wr = m[1];
      ef = m[0] ? 3'b001 : (m[1] ? 3'b010 : 3'b100);
      es = m[0] ? 2'd2 : (m[1] ? 2'd1 : 2'd0);
      @(negedge clk);
      chk("R9 flags_out", {29'd0, flags_out}, {29'd0, ef});
      chk("R9 flag_sel", {30'd0, flag_sel}, {30'd0, es});
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_combos();
    t_wb_mem();
    t_wen_low();
    t_split_srcs();
    t_reg_zero();
    t_imm_a_ignored();
    t_flags();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule